// File: doc/BRIEF.md
# Accumulator Bitfield Extract Unit

This unit keeps four 64-bit accumulators and one 32-bit control word. Its main job is to pull a bitfield of 1 to 32 bits out of a chosen accumulator and return it as a right-aligned 32-bit word. The control word's position field gives the field's most significant bit. The position is not the field's lowest bit.

A second extract opcode lowers the position by the field length after a successful extract. Software can use it to unpack a run of adjacent fields from the top down. A move opcode copies the low word of an accumulator into its high word, loads a new low word, and advances the position by 32.

The control word also collects sticky overflow flags. These come from neighbouring datapaths, one flag per destination accumulator and one per kind of operation. It also holds a carry bit and a shift-count field. Every command completes in one cycle.

Top module: `acc_extract_unit`

## Requirements
- R1: After reset, `ctrl_o` is zero, `res_valid_o` is low, and every accumulator reads back as zero.
- R2: Opcode 1 writes `cmd_data_i` into the low 32 bits of the accumulator chosen by `cmd_acc_i`. Opcode 2 writes the high 32 bits. No other accumulator changes.
- R3: Extract (opcode 3 or 4) takes length L = `cmd_size_i`+1 and position P = `ctrl_o[5:0]`. When P >= `cmd_size_i`, `res_data_o[L-1:0]` equals accumulator bits P down to P-`cmd_size_i`, and the remaining result bits are zero. `res_valid_o` is high for exactly the one cycle after an extract command is accepted.
- R4: When P < `cmd_size_i`, an extract reports failure: `res_efail_o` = 1 and `res_data_o` = 0. Every extract copies its failure flag into `ctrl_o[14]`, so a successful extract clears that bit.
- R5: Opcode 3 leaves the position unchanged. Opcode 4 sets the position to P-L modulo 64 after a successful extract, and leaves it unchanged on failure.
- R6: Opcode 5 copies the selected accumulator's low word into its high word, loads `cmd_data_i` into the low word, and sets the position to P+32 modulo 64.
- R7: Opcode 6 loads `cmd_data_i` into the control word. Only the defined fields are kept: position [5:0], shift count [12:7], carry [13], extract failure [14], and overflow flags [23:16]. All other bits read zero.
- R8: A high bit k of `ovf_acc_i` sets `ctrl_o[16+k]`. Once set, the bit stays set until an opcode 6 write.
- R9: High bits 0, 1, 2 and 3 of `ovf_kind_i` set `ctrl_o[20]`, `[21]`, `[22]` and `[23]` respectively: add/subtract, multiply, left shift or narrowing, and accumulator shift-extract. These flags are sticky in the same way as in R8.
- R10: An opcode 6 write takes priority over overflow reports and carry updates that arrive in the same cycle.
- R11: When `carry_we_i` is high, `ctrl_o[13]` takes the value of `carry_i`. Otherwise the carry bit holds.
- R12: Opcode 0, opcode 7, and any command with `cmd_valid_i` low change neither the accumulators nor the control word, and do not raise `res_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Opcode: 0 none, 1 load low, 2 load high, 3 extract, 4 extract with decrement, 5 low-to-high move, 6 control write |
| cmd_acc_i | input | 2 | Accumulator select, 0 to 3 |
| cmd_size_i | input | 5 | Field length minus one |
| cmd_data_i | input | 32 | Load data or control write data |
| ovf_acc_i | input | 4 | Overflow reports per destination accumulator |
| ovf_kind_i | input | 4 | Overflow reports per operation kind |
| carry_we_i | input | 1 | Carry bit update enable |
| carry_i | input | 1 | New carry value |
| res_valid_o | output | 1 | Extract result valid |
| res_data_o | output | 32 | Extracted field, right-aligned |
| res_efail_o | output | 1 | Last extract had too few bits |
| ctrl_o | output | 32 | Control word |

## Verification
Every command and every overflow or carry report shows up at the ports one clock edge after it is presented. The unit has one register stage and nothing else on the path. This holds for the result port and for the control word alike.

The bench drives stimulus at a falling edge and holds it through the next rising edge. It removes the stimulus at the following falling edge and compares the outputs at that same falling edge. Each check therefore looks at the cycle in which the result is due.

Accumulator contents are read back through extracts at positions 31 and 63. An extract with opcode 3 leaves the position unchanged, so each readback sits between the stimulus under test and the next one without disturbing the state being checked.

// File: rtl/acc_extract_pkg.sv
`timescale 1ns/1ps
package acc_extract_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_LOAD_LO  = 3'd1,
    OP_LOAD_HI  = 3'd2,
    OP_EXTR     = 3'd3,
    OP_EXTR_DEC = 3'd4,
    OP_MOVE_LH  = 3'd5,
    OP_CTRL_WR  = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  localparam int CTRL_W       = 32;
  localparam int POS_LSB      = 0;
  localparam int POS_W        = 6;
  localparam int SCNT_LSB     = 7;
  localparam int SCNT_W       = 6;
  localparam int CARRY_BIT    = 13;
  localparam int EFAIL_BIT    = 14;
  localparam int OVF_ACC_LSB  = 16;
  localparam int OVF_KIND_LSB = 20;
  localparam int NUM_KIND     = 4;

  localparam logic [CTRL_W-1:0] CTRL_MASK = 32'h00FF_7FBF;

endpackage

// File: rtl/acc_bank.sv
`timescale 1ns/1ps
module acc_bank #(
  parameter int N_ACC = 4,
  parameter int ACC_W = 64,
  localparam int SEL_W  = $clog2(N_ACC),
  localparam int HALF_W = ACC_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              move_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [HALF_W-1:0] data_i,
  output logic [ACC_W-1:0]  rd_o
);

  logic [ACC_W-1:0] acc_q [N_ACC];

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    logic hit;
    assign hit = (sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q[g] <= '0;
      end else if (hit) begin
        if (move_i) begin
          acc_q[g] <= {acc_q[g][HALF_W-1:0], data_i};
        end else if (wr_lo_i) begin
          acc_q[g][HALF_W-1:0] <= data_i;
        end else if (wr_hi_i) begin
          acc_q[g][ACC_W-1:HALF_W] <= data_i;
        end
      end
    end
  end

  assign rd_o = acc_q[sel_i];

endmodule

// File: rtl/field_extract.sv
`timescale 1ns/1ps
module field_extract #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  localparam int POS_W  = $clog2(ACC_W),
  localparam int SIZE_W = $clog2(RES_W)
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [RES_W-1:0]  field_o,
  output logic              fail_o,
  output logic [POS_W-1:0]  pos_dec_o
);

  localparam logic [SIZE_W-1:0] TOP_IDX = SIZE_W'(RES_W - 1);

  logic [POS_W-1:0]  base;
  logic [SIZE_W-1:0] mask_sh;
  logic [RES_W-1:0]  low_bits;
  logic [RES_W-1:0]  mask;

  assign fail_o   = pos_i < POS_W'(size_i);
  assign base     = pos_i - POS_W'(size_i);
  assign low_bits = RES_W'(acc_i >> base);
  assign mask_sh  = TOP_IDX - size_i;
  assign mask     = {RES_W{1'b1}} >> mask_sh;
  assign field_o  = fail_o ? '0 : (low_bits & mask);
  // field length is size+1
  assign pos_dec_o = base - POS_W'(1);

endmodule

// File: rtl/ctrl_reg.sv
`timescale 1ns/1ps
module ctrl_reg
  import acc_extract_pkg::*;
#(
  parameter int N_ACC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              pos_ld_i,
  input  logic [POS_W-1:0]  pos_nxt_i,
  input  logic              efail_ld_i,
  input  logic              efail_i,
  input  logic [N_ACC-1:0]  ovf_acc_i,
  input  logic [NUM_KIND-1:0] ovf_kind_i,
  input  logic              carry_we_i,
  input  logic              carry_i,
  output logic [CTRL_W-1:0] ctrl_o
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) begin
      ctrl_d = wr_data_i & CTRL_MASK;
    end else begin
      if (pos_ld_i)   ctrl_d[POS_LSB +: POS_W] = pos_nxt_i;
      if (efail_ld_i) ctrl_d[EFAIL_BIT]        = efail_i;
      if (carry_we_i) ctrl_d[CARRY_BIT]        = carry_i;
      ctrl_d[OVF_ACC_LSB  +: N_ACC]    = ctrl_q[OVF_ACC_LSB  +: N_ACC]    | ovf_acc_i;
      ctrl_d[OVF_KIND_LSB +: NUM_KIND] = ctrl_q[OVF_KIND_LSB +: NUM_KIND] | ovf_kind_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/acc_extract_unit.sv
`timescale 1ns/1ps
module acc_extract_unit
  import acc_extract_pkg::*;
#(
  parameter int N_ACC = 4,
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  localparam int SEL_W  = $clog2(N_ACC),
  localparam int SIZE_W = $clog2(RES_W),
  localparam int HALF_W = ACC_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_acc_i,
  input  logic [SIZE_W-1:0] cmd_size_i,
  input  logic [HALF_W-1:0] cmd_data_i,
  input  logic [N_ACC-1:0]  ovf_acc_i,
  input  logic [3:0]        ovf_kind_i,
  input  logic              carry_we_i,
  input  logic              carry_i,
  output logic              res_valid_o,
  output logic [RES_W-1:0]  res_data_o,
  output logic              res_efail_o,
  output logic [31:0]       ctrl_o
);

  op_e op;
  logic do_lo, do_hi, do_ext, do_dec, do_mv, do_cw;
  logic [ACC_W-1:0]  acc_rd;
  logic [RES_W-1:0]  field;
  logic              fail;
  logic [POS_W-1:0]  pos, pos_dec, pos_nxt;
  logic [CTRL_W-1:0] ctrl;

  assign op     = op_e'(cmd_op_i);
  assign do_lo  = cmd_valid_i && (op == OP_LOAD_LO);
  assign do_hi  = cmd_valid_i && (op == OP_LOAD_HI);
  assign do_dec = cmd_valid_i && (op == OP_EXTR_DEC);
  assign do_ext = cmd_valid_i && ((op == OP_EXTR) || (op == OP_EXTR_DEC));
  assign do_mv  = cmd_valid_i && (op == OP_MOVE_LH);
  assign do_cw  = cmd_valid_i && (op == OP_CTRL_WR);

  assign pos = ctrl[POS_LSB +: POS_W];

  acc_bank #(.N_ACC(N_ACC), .ACC_W(ACC_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (do_lo),
    .wr_hi_i (do_hi),
    .move_i  (do_mv),
    .sel_i   (cmd_acc_i),
    .data_i  (cmd_data_i),
    .rd_o    (acc_rd)
  );

  field_extract #(.ACC_W(ACC_W), .RES_W(RES_W)) u_fx (
    .acc_i     (acc_rd),
    .pos_i     (pos),
    .size_i    (cmd_size_i),
    .field_o   (field),
    .fail_o    (fail),
    .pos_dec_o (pos_dec)
  );

  assign pos_nxt = do_mv ? (pos + POS_W'(HALF_W)) : pos_dec;

  ctrl_reg #(.N_ACC(N_ACC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (do_cw),
    .wr_data_i  (CTRL_W'(cmd_data_i)),
    .pos_ld_i   (do_mv || (do_dec && !fail)),
    .pos_nxt_i  (pos_nxt),
    .efail_ld_i (do_ext),
    .efail_i    (fail),
    .ovf_acc_i  (ovf_acc_i),
    .ovf_kind_i (ovf_kind_i),
    .carry_we_i (carry_we_i),
    .carry_i    (carry_i),
    .ctrl_o     (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_efail_o <= 1'b0;
    end else begin
      res_valid_o <= do_ext;
      if (do_ext) begin
        res_data_o  <= field;
        res_efail_o <= fail;
      end
    end
  end

  assign ctrl_o = ctrl;

endmodule

// File: rtl/acc_extract_chk.sv
`timescale 1ns/1ps
module acc_extract_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic [2:0]  cmd_op_i,
  input logic [31:0] cmd_data_i,
  input logic [3:0]  ovf_kind_i,
  input logic        res_valid_o,
  input logic [31:0] res_data_o,
  input logic        res_efail_o,
  input logic [31:0] ctrl_o
);

  logic ext_cmd, cw_cmd, mv_cmd, plain_ext;
  assign ext_cmd   = cmd_valid_i && (cmd_op_i == 3'd3 || cmd_op_i == 3'd4);
  assign plain_ext = cmd_valid_i && (cmd_op_i == 3'd3);
  assign cw_cmd    = cmd_valid_i && (cmd_op_i == 3'd6);
  assign mv_cmd    = cmd_valid_i && (cmd_op_i == 3'd5);

  // R3
  res_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_cmd |=> res_valid_o);
  // R12
  no_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_cmd |=> !res_valid_o);
  // R4
  efail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_efail_o) |-> (res_data_o == 32'd0));
  // R4
  efail_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (ctrl_o[14] == res_efail_o));
  // R5
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_ext |=> (ctrl_o[5:0] == $past(ctrl_o[5:0])));
  // R6
  move_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_cmd |=> (ctrl_o[5:0] == 6'($past(ctrl_o[5:0]) + 6'd32)));
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cw_cmd |=> ((ctrl_o[23:16] & $past(ctrl_o[23:16])) == $past(ctrl_o[23:16])));
  // R9
  kind_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cw_cmd && ovf_kind_i != 4'd0) |=> ((ctrl_o[23:20] & $past(ovf_kind_i)) == $past(ovf_kind_i)));
  // R10
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_cmd |=> (ctrl_o == ($past(cmd_data_i) & 32'h00FF_7FBF)));

endmodule

bind acc_extract_unit acc_extract_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_data_i  (cmd_data_i),
  .ovf_kind_i  (ovf_kind_i),
  .res_valid_o (res_valid_o),
  .res_data_o  (res_data_o),
  .res_efail_o (res_efail_o),
  .ctrl_o      (ctrl_o)
);

// File: tb/acc_extract_unit_bench.sv
`timescale 1ns/1ps
module acc_extract_unit_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [1:0]  cmd_acc_i = '0;
  logic [4:0]  cmd_size_i = '0;
  logic [31:0] cmd_data_i = '0;
  logic [3:0]  ovf_acc_i = '0;
  logic [3:0]  ovf_kind_i = '0;
  logic        carry_we_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        res_valid_o;
  logic [31:0] res_data_o;
  logic        res_efail_o;
  logic [31:0] ctrl_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [63:0] acc_m [4];

  always #5 clk = ~clk;

  acc_extract_unit u_acc_extract_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_acc_i(cmd_acc_i), .cmd_size_i(cmd_size_i), .cmd_data_i(cmd_data_i),
    .ovf_acc_i(ovf_acc_i), .ovf_kind_i(ovf_kind_i), .carry_we_i(carry_we_i),
    .carry_i(carry_i), .res_valid_o(res_valid_o), .res_data_o(res_data_o),
    .res_efail_o(res_efail_o), .ctrl_o(ctrl_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; outputs are due at the next falling edge.
  task automatic step(input logic v, input logic [2:0] op, input logic [1:0] a,
                      input logic [4:0] sz, input logic [31:0] d,
                      input logic [3:0] oa, input logic [3:0] ok,
                      input logic cwe, input logic c);
    cmd_valid_i = v; cmd_op_i = op; cmd_acc_i = a; cmd_size_i = sz; cmd_data_i = d;
    ovf_acc_i = oa; ovf_kind_i = ok; carry_we_i = cwe; carry_i = c;
    @(negedge clk);
    cmd_valid_i = 1'b0; ovf_acc_i = '0; ovf_kind_i = '0; carry_we_i = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] a, input logic [4:0] sz,
                     input logic [31:0] d);
    step(1'b1, op, a, sz, d, 4'd0, 4'd0, 1'b0, 1'b0);
  endtask

  function automatic logic [31:0] exp_field(input logic [63:0] a, input int p, input int s);
    logic [31:0] r = '0;
    if (p < s) return 32'd0;
    for (int i = 0; i <= s; i++) r[i] = a[p - s + i];
    return r;
  endfunction

  // Reads both halves via plain extracts; leaves pos at 63.
  task automatic read_acc(input string req, input int a);
    cmd(3'd6, 2'd0, 5'd0, 32'd31);
    cmd(3'd3, 2'(a), 5'd31, 32'd0);
    chk(req, {32'd0, res_data_o}, {32'd0, acc_m[a][31:0]});
    cmd(3'd6, 2'd0, 5'd0, 32'd63);
    cmd(3'd3, 2'(a), 5'd31, 32'd0);
    chk(req, {32'd0, res_data_o}, {32'd0, acc_m[a][63:32]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", {32'd0, ctrl_o}, 64'd0);
    chk("R1 valid", {63'd0, res_valid_o}, 64'd0);
    for (int a = 0; a < 4; a++) begin
      acc_m[a] = 64'd0;
      read_acc("R1 acc", a);
    end

    // R2 loads to each accumulator
    for (int a = 0; a < 4; a++) begin
      acc_m[a] = 64'h9E37_79B9_7F4A_7C15 * 64'(a + 3);
      cmd(3'd1, 2'(a), 5'd0, acc_m[a][31:0]);
      cmd(3'd2, 2'(a), 5'd0, acc_m[a][63:32]);
    end
    for (int a = 0; a < 4; a++) read_acc("R2 load", a);

    // R3 R4 sweep of position and size on acc 2
    for (int p = 0; p < 64; p++) begin
      for (int s = 0; s < 32; s++) begin
        cmd(3'd6, 2'd0, 5'd0, 32'(p));
        cmd(3'd3, 2'd2, 5'(s), 32'd0);
        chk("R3 data", {32'd0, res_data_o}, {32'd0, exp_field(acc_m[2], p, s)});
        chk("R4 efail", {63'd0, res_efail_o}, {63'd0, p < s});
        chk("R4 ctrl14", {63'd0, ctrl_o[14]}, {63'd0, p < s});
        chk("R3 valid", {63'd0, res_valid_o}, 64'd1);
        chk("R5 pos hold", {58'd0, ctrl_o[5:0]}, 64'(p));
      end
    end

    // R5 decrementing unpack of 8-bit fields from the top of acc 1
    cmd(3'd6, 2'd0, 5'd0, 32'd63);
    for (int k = 0; k < 8; k++) begin
      cmd(3'd4, 2'd1, 5'd7, 32'd0);
      chk("R5 dec data", {32'd0, res_data_o}, {56'd0, acc_m[1][63 - 8*k -: 8]});
      chk("R5 dec pos", {58'd0, ctrl_o[5:0]}, 64'((63 - 8*(k+1)) & 63));
    end
    cmd(3'd6, 2'd0, 5'd0, 32'd3);
    cmd(3'd4, 2'd1, 5'd7, 32'd0);
    chk("R5 fail pos", {58'd0, ctrl_o[5:0]}, 64'd3);
    chk("R4 fail flag", {63'd0, res_efail_o}, 64'd1);
    cmd(3'd6, 2'd0, 5'd0, 32'd5);
    cmd(3'd4, 2'd1, 5'd5, 32'd0);
    chk("R5 wrap pos", {58'd0, ctrl_o[5:0]}, 64'd63);
    chk("R5 wrap data", {32'd0, res_data_o}, {32'd0, exp_field(acc_m[1], 5, 5)});

    // R6 low-to-high move with position wrap
    cmd(3'd6, 2'd0, 5'd0, 32'd40);
    cmd(3'd5, 2'd3, 5'd0, 32'hC0DE_1234);
    chk("R6 pos", {58'd0, ctrl_o[5:0]}, 64'd8);
    acc_m[3] = {acc_m[3][31:0], 32'hC0DE_1234};
    read_acc("R6 acc3", 3);
    read_acc("R6 acc0 untouched", 0);

    // R7 control write mask
    cmd(3'd6, 2'd0, 5'd0, 32'hFFFF_FFFF);
    chk("R7 mask", {32'd0, ctrl_o}, 64'h0000_0000_00FF_7FBF);
    cmd(3'd6, 2'd0, 5'd0, 32'd0);
    chk("R7 clear", {32'd0, ctrl_o}, 64'd0);

    // R8 R9 sticky flags, one bit at a time
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 3'd0, 2'd0, 5'd0, 32'd0, 4'(1 << k), 4'd0, 1'b0, 1'b0);
      chk("R8 acc flag", {40'd0, ctrl_o[23:16]}, 64'((1 << (k+1)) - 1));
    end
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 3'd0, 2'd0, 5'd0, 32'd0, 4'd0, 4'(1 << k), 1'b0, 1'b0);
      chk("R9 kind flag", {60'd0, ctrl_o[23:20]}, 64'((1 << (k+1)) - 1));
    end
    step(1'b0, 3'd0, 2'd0, 5'd0, 32'd0, 4'd0, 4'd0, 1'b0, 1'b0);
    chk("R8 hold", {40'd0, ctrl_o[23:16]}, 64'hFF);

    // R11 carry
    step(1'b0, 3'd0, 2'd0, 5'd0, 32'd0, 4'd0, 4'd0, 1'b1, 1'b1);
    chk("R11 carry set", {63'd0, ctrl_o[13]}, 64'd1);
    step(1'b0, 3'd0, 2'd0, 5'd0, 32'd0, 4'd0, 4'd0, 1'b0, 1'b0);
    chk("R11 carry hold", {63'd0, ctrl_o[13]}, 64'd1);
    step(1'b0, 3'd0, 2'd0, 5'd0, 32'd0, 4'd0, 4'd0, 1'b1, 1'b0);
    chk("R11 carry clr", {63'd0, ctrl_o[13]}, 64'd0);

    // R10 write beats same-cycle reports
    step(1'b1, 3'd6, 2'd0, 5'd0, 32'h0000_0011, 4'hF, 4'hF, 1'b1, 1'b1);
    chk("R10 priority", {32'd0, ctrl_o}, 64'h11);

    // R12 ignored commands
    step(1'b1, 3'd7, 2'd0, 5'd9, 32'hDEAD_BEEF, 4'd0, 4'd0, 1'b0, 1'b0);
    chk("R12 rsvd ctrl", {32'd0, ctrl_o}, 64'h11);
    chk("R12 rsvd valid", {63'd0, res_valid_o}, 64'd0);
    step(1'b0, 3'd1, 2'd0, 5'd0, 32'hDEAD_BEEF, 4'd0, 4'd0, 1'b0, 1'b0);
    step(1'b0, 3'd5, 2'd0, 5'd0, 32'hDEAD_BEEF, 4'd0, 4'd0, 1'b0, 1'b0);
    step(1'b1, 3'd0, 2'd0, 5'd0, 32'hDEAD_BEEF, 4'd0, 4'd0, 1'b0, 1'b0);
    chk("R12 idle ctrl", {32'd0, ctrl_o}, 64'h11);
    chk("R12 idle valid", {63'd0, res_valid_o}, 64'd0);
    read_acc("R12 acc0", 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule